// File: doc/BRIEF.md
# Floating-Point Exception Mask and Signaling Unit

This unit sits next to a floating-point datapath and converts per-operation exception pulses into sticky status flags, an error summary, and one of two error deliveries. Six exception classes are tracked. A control word supplies one mask bit per class. A masked class only records its flag, and execution carries on without interruption. An unmasked class that has its flag set makes the error summary true.

A mode input picks how the summary is delivered. In internal mode, the summary raises a one-cycle math-fault request carrying vector 16 at the next instruction that waits on the floating-point unit. In external mode, the summary drives an active-low error pin. The summary also freezes the issue of the next waiting floating-point instruction or WAIT instruction. An ignore-error input lifts that freeze so that a handler can run floating-point code while the pin is still low. The pin is released only when software clears the status flags.

The instruction-issue logic presents a decoded class for each instruction, and it honours the stall output.

Top module: `fpu_xcpt_unit`

## Requirements
- R1: While reset is held and right after it, `status` is 0, `err_sum` is 0, `err_pin_n` is 1, `stall` is 0, `fault_req` is 0 and `fault_vec` is 0.
- R2: A 1 on `exc_evt[i]` sets `status[i]` at the next clock edge, and the flag stays set until a clear. The bit order is: 0 invalid operation or stack fault, 1 divide by zero, 2 denormal operand, 3 overflow, 4 underflow, 5 inexact.
- R3: A `clr_req` zeroes `status` at the next edge. Any `exc_evt` bits present in the same cycle are still recorded.
- R4: `err_sum` is the OR of each `status[i]` whose mask bit `ctrl_word[i]` is 0 (1 means masked). `ctrl_word[15:6]` has no effect.
- R5: An exception whose class is masked leaves `err_pin_n` high, `stall` low and `fault_req` low.
- R6: With `fault_mode`=0, `err_pin_n` is the inverse of `err_sum`.
- R7: With `fault_mode`=0, `err_sum`=1 and `ign_err`=0, `stall` is 1 when `insn_kind` is 2'b01 (waiting floating-point) or 2'b11 (WAIT). It is 0 for 2'b10 (non-waiting floating-point) and 2'b00 (no floating-point instruction).
- R8: `ign_err`=1 forces `stall` to 0, and `err_pin_n` stays low.
- R9: With `fault_mode`=1, `err_pin_n` stays 1 and `stall` stays 0. `fault_req` pulses for one cycle at the first waiting or WAIT instruction seen while `err_sum` is 1. It does not pulse again until `err_sum` has returned to 0.
- R10: `fault_vec` is 16 while `fault_req` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_evt | input | 6 | Exception pulses, one per class |
| ctrl_word | input | 16 | Control word; bits 5:0 are the class masks |
| clr_req | input | 1 | Clear all status flags |
| fault_mode | input | 1 | 1 selects internal fault, 0 selects external pin |
| ign_err | input | 1 | Ignore pending error for the stall |
| insn_kind | input | 2 | Decoded class of the instruction at issue |
| status | output | 6 | Sticky exception flags |
| err_sum | output | 1 | Summary of unmasked set flags |
| fault_req | output | 1 | One-cycle internal math-fault request |
| err_pin_n | output | 1 | Active-low external error pin |
| stall | output | 1 | Freeze issue of the presented instruction |
| fault_vec | output | 8 | Fault vector, valid with fault_req |

## Verification
The assertions assume that reset is applied before use and that `insn_kind` is a settled decode in every cycle. They place no limit on how the mask, mode or ignore input may change. The stimulus respects this: it changes inputs only between edges, and it draws mode, mask and ignore values freely. Events and clears are kept sparse so that error episodes last long enough for the stall and the fault pulse to be seen over several instructions.

// File: rtl/fpu_xcpt_unit.sv
module fpu_xcpt_unit #(
  parameter int N_CLS     = 6,
  parameter int CW_W      = 16,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CLS-1:0] exc_evt,
  input  logic [CW_W-1:0]  ctrl_word,
  input  logic             clr_req,
  input  logic             fault_mode,
  input  logic             ign_err,
  input  logic [1:0]       insn_kind,
  output logic [N_CLS-1:0] status,
  output logic             err_sum,
  output logic             fault_req,
  output logic             err_pin_n,
  output logic             stall,
  output logic [VEC_W-1:0] fault_vec
);
  localparam logic [1:0] KIND_WAITING = 2'b01;
  localparam logic [1:0] KIND_WAIT    = 2'b11;

  logic fired_q;
  logic waits;
  logic unused_cw;

  assign unused_cw = ^ctrl_word[CW_W-1:N_CLS];
  assign waits     = (insn_kind == KIND_WAITING) || (insn_kind == KIND_WAIT);
  assign err_sum   = |(status & ~ctrl_word[N_CLS-1:0]);
  assign err_pin_n = ~(err_sum & ~fault_mode);
  assign stall     = err_sum & ~fault_mode & ~ign_err & waits;
  assign fault_req = err_sum & fault_mode & waits & ~fired_q;
  assign fault_vec = fault_req ? VEC_W'(FAULT_VEC) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      fired_q <= 1'b0;
    end else begin
      status  <= (clr_req ? '0 : status) | exc_evt;
      fired_q <= err_sum & fault_mode & (fired_q | fault_req);
    end
  end
endmodule

// File: rtl/fpu_xcpt_unit_chk.sv
module fpu_xcpt_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] exc_evt,
  input logic [15:0] ctrl_word,
  input logic       clr_req,
  input logic       fault_mode,
  input logic       ign_err,
  input logic [5:0] status,
  input logic       fault_req,
  input logic       err_pin_n,
  input logic       stall,
  input logic [7:0] fault_vec
);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> ((status & $past(status)) == $past(status)));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (status == $past(exc_evt)));
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~ctrl_word[5:0]) == 6'd0) |-> (err_pin_n && !stall && !fault_req));
  assert_pin_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pin_n |-> (!fault_mode && ((status & ~ctrl_word[5:0]) != 6'd0)));
  assert_stall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!fault_mode && !err_pin_n));
  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ign_err |-> !stall);
  assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> !fault_req);
  assert_internal_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_mode |-> err_pin_n);
  assert_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req ? (fault_vec == 8'd16) : (fault_vec == 8'd0));
endmodule

bind fpu_xcpt_unit fpu_xcpt_unit_chk i_chk (.*);

// File: tb/test_fpu_xcpt_unit.sv
`timescale 1ns/1ps
module test_fpu_xcpt_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] exc_evt;
  logic [15:0] ctrl_word;
  logic       clr_req, fault_mode, ign_err;
  logic [1:0] insn_kind;
  logic [5:0] status;
  logic       err_sum, fault_req, err_pin_n, stall;
  logic [7:0] fault_vec;

  int errors = 0;
  int checks = 0;
  logic [5:0] m_stat;
  logic       m_fired;

  always #4 clk = ~clk;

  fpu_xcpt_unit i_fpu_xcpt_unit (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic e_sum();
    return |(m_stat & ~ctrl_word[5:0]);
  endfunction
  function automatic logic e_waits();
    return insn_kind == 2'b01 || insn_kind == 2'b11;
  endfunction
  function automatic logic e_stall();
    return e_sum() && !fault_mode && !ign_err && e_waits();
  endfunction
  function automatic logic e_fault();
    return e_sum() && fault_mode && e_waits() && !m_fired;
  endfunction

  task automatic step();
    logic f;
    #1;
    f = e_fault();
    chk("R2 status", status, m_stat);
    chk("R4 err_sum", err_sum, e_sum());
    chk("R6 err_pin_n", err_pin_n, !(e_sum() && !fault_mode));
    chk("R7 stall", stall, e_stall());
    chk("R9 fault_req", fault_req, f);
    chk("R10 fault_vec", fault_vec, f ? 16 : 0);
    @(posedge clk);
    m_fired = e_sum() && fault_mode && (m_fired || f);
    m_stat  = (clr_req ? 6'd0 : m_stat) | exc_evt;
    @(negedge clk);
    exc_evt = '0;
    clr_req = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd9127);
    rst_n = 1'b0; exc_evt = '0; ctrl_word = 16'h0000; clr_req = 1'b0;
    fault_mode = 1'b0; ign_err = 1'b0; insn_kind = 2'b01;
    m_stat = '0; m_fired = 1'b0;
    exc_evt = 6'h3F;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 status", status, 0);
    chk("R1 pin", err_pin_n, 1);
    chk("R1 stall", stall, 0);
    chk("R1 fault", fault_req, 0);
    rst_n = 1'b1; exc_evt = '0;
    #1;
    chk("R1 vec", fault_vec, 0);
    chk("R1 sum", err_sum, 0);

    exc_evt = 6'b000010; step();
    chk("R2 divide flag in bit 1", status, 6'b000010);
    insn_kind = 2'b01; #1; chk("R7 waiting stalls", stall, 1);
    insn_kind = 2'b10; #1; chk("R7 non-waiting runs", stall, 0);
    insn_kind = 2'b11; #1; chk("R7 WAIT stalls", stall, 1);
    step();
    ign_err = 1'b1; insn_kind = 2'b01; #1;
    chk("R8 ignore lifts stall", stall, 0);
    chk("R8 pin still low", err_pin_n, 0);
    step();
    ign_err = 1'b0;
    exc_evt = 6'b100000; clr_req = 1'b1; step();
    chk("R3 clear keeps same-cycle event", status, 6'b100000);
    ctrl_word = 16'hFFC0; #1;
    chk("R4 upper control bits ignored", err_sum, 1);
    ctrl_word = 16'h003F; #1;
    chk("R5 masked pin high", err_pin_n, 1);
    chk("R5 masked no stall", stall, 0);
    step();

    clr_req = 1'b1; ctrl_word = 16'h0000; fault_mode = 1'b1; insn_kind = 2'b10; step();
    exc_evt = 6'b000001; step();
    insn_kind = 2'b01; #1;
    chk("R9 fault at waiting insn", fault_req, 1);
    chk("R10 vector 16", fault_vec, 16);
    chk("R9 pin high internal", err_pin_n, 1);
    step();
    chk("R9 no second pulse", fault_req, 0);
    step(); step();
    clr_req = 1'b1; step(); step();
    exc_evt = 6'b001000; step();
    #1; chk("R9 new episode pulses", fault_req, 1);
    step();

    for (int i = 0; i < 4000; i++) begin
      exc_evt    = ($urandom % 8 == 0) ? 6'($urandom) : 6'd0;
      clr_req    = ($urandom % 12 == 0);
      if ($urandom % 20 == 0) ctrl_word  = 16'($urandom);
      if ($urandom % 40 == 0) fault_mode = 1'($urandom);
      if ($urandom % 10 == 0) ign_err    = 1'($urandom);
      insn_kind  = 2'($urandom);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule